// File: doc/BRIEF.md
# Weighted Pseudo-Random Test Pattern Generator

This block produces stimulus vectors for on-chip self-test. Its core is an n-bit shift register with fixed XOR feedback: each advance moves every bit one place toward bit 0, and the parity of the tapped bits enters at the top. With a primitive tap set the register walks every nonzero state once before it repeats. A shaping stage then turns each register state into the vector that is driven out, in one of three ways chosen by a mode input.

In raw mode the state goes out as it is. In weighted mode a state that is dense in ones is replaced by an all-ones vector, so that such vectors occur far more often than they would by chance. In pair mode one state yields two vectors on successive enabled cycles. The first, the launch vector, is the state XORed with a copy of itself rotated toward the MSB by one amount. The second, the capture vector, uses a second rotation amount. These pairs drive at-speed transition tests. A seed can be loaded at any time, and a zero seed is replaced by the reset seed, so the register cannot lock up.

Every output is registered. A vector requested in one cycle appears after the next rising clock edge, and it is marked by the valid flag.

Top module: `wtpg`

## Requirements
- R1: On each advance the state shifts one place toward bit 0, and the XOR of the tapped bits enters bit WIDTH-1. With WIDTH=4 and taps on bits 0 and 1, loading 1001 and running raw mode emits 1001, 1100, 0110, 1011.
- R2: With the default WIDTH=8 and taps on bits 0, 2, 3 and 4, starting from 8'h01 in raw mode, the state comes back to 8'h01 only after 255 advances and never becomes zero along the way.
- R3: The state is never zero. Loading a zero seed loads the reset seed (8'h01 by default) in its place.
- R4: After reset the state holds the reset seed, and valid, capture and pattern are all 0. The first vector emitted in raw mode equals the reset seed.
- R5: Load takes priority over enable. A cycle with load high emits no vector, so valid is low after it, and the next vector comes from the loaded seed.
- R6: The mode is encoded as 0 for raw, 1 for weighted and 2 for pair; code 3 behaves as raw. In raw mode the pattern equals the state, and the state advances on every enabled cycle.
- R7: In weighted mode (1), a state with more than WEIGHT_ABOVE ones (default 6) is emitted as all ones. Any other state is emitted unchanged. The state advances on every enabled cycle.
- R8: In pair mode (2), the first enabled cycle emits launch = s ^ rotl(s,1) with capture low. The next enabled cycle emits capture = s ^ rotl(s,2) with capture high. Only after the capture vector does the state advance, once. Enabling a mode other than pair restarts the next pair at its launch vector.
- R9: valid goes high in the cycle after each enabled cycle without a load, and in no other cycle. In a cycle without a new vector, the pattern holds, capture is low and the state does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Produce one vector this cycle |
| load | input | 1 | Load seed into the register (wins over en) |
| seed | input | WIDTH | Seed value; zero is replaced by the reset seed |
| mode | input | 2 | 0 raw, 1 weighted, 2 launch/capture pair, 3 raw |
| pattern | output | WIDTH | Current test vector |
| valid | output | 1 | pattern carries a new vector this cycle |
| capture | output | 1 | pattern is the capture half of a pair |

## Verification
A register that takes a wrong feedback bit shows up in raw mode one cycle later: the top bit of the next emitted vector is wrong while its lower bits are still the previous vector shifted. A lost or extra advance in pair mode shows up within two vectors, because the next launch vector is then built from the wrong state. A phase flag stuck at one value makes the capture flag either never rise or rise on every vector. A weighting comparator that is off by one changes the output only for states that sit exactly at the threshold. For that reason the stimulus places seeds with six and with seven ones directly on that boundary.

// File: rtl/wtpg_pkg.sv
package wtpg_pkg;

  typedef enum logic [1:0] {
    MODE_RAW    = 2'd0,
    MODE_WEIGHT = 2'd1,
    MODE_PAIR   = 2'd2,
    MODE_SPARE  = 2'd3
  } mode_e;

endpackage

// File: rtl/wtpg_lfsr.sv
module wtpg_lfsr #(
  parameter int                WIDTH      = 8,
  parameter logic [WIDTH-1:0]  TAPS       = 8'h1D,
  parameter logic [WIDTH-1:0]  RESET_SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             adv_i,
  output logic [WIDTH-1:0] state_o
);

  // next state: shift toward bit 0, parity of taps enters at the top
  function automatic logic [WIDTH-1:0] step_fn(input logic [WIDTH-1:0] s);
    return {^(s & TAPS), s[WIDTH-1:1]};
  endfunction

  logic [WIDTH-1:0] state_q;
  logic             zero_seed;
  logic [WIDTH-1:0] seed_safe;

  assign zero_seed = (seed_i == '0);
  assign seed_safe = zero_seed ? RESET_SEED : seed_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= RESET_SEED;
    else if (load_i)  state_q <= seed_safe;
    else if (adv_i)   state_q <= step_fn(state_q);
  end

  assign state_o = state_q;

  // R3
  nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R3
  zero_seed_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && zero_seed) |=> (state_q == RESET_SEED));

  // R1
  shift_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1])));

  // R9
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(state_q));

endmodule

// File: rtl/wtpg_shaper.sv
module wtpg_shaper
  import wtpg_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int WEIGHT_ABOVE = (3 * WIDTH) / 4,
  parameter int ROT_LAUNCH   = 1,
  parameter int ROT_CAPTURE  = 2
) (
  input  logic [WIDTH-1:0] state_i,
  input  mode_e            mode_i,
  input  logic             second_i,
  output logic [WIDTH-1:0] vec_o
);

  localparam int CW = $clog2(WIDTH + 1);

  function automatic logic [CW-1:0] ones_fn(input logic [WIDTH-1:0] s);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < WIDTH; i++) n = n + CW'(s[i]);
    return n;
  endfunction

  // rotate toward the MSB by amt places
  function automatic logic [WIDTH-1:0] rotl_fn(input logic [WIDTH-1:0] s, input int amt);
    logic [2*WIDTH-1:0] d;
    d = {s, s};
    return d[WIDTH-amt +: WIDTH];
  endfunction

  logic             dense;
  logic [WIDTH-1:0] launch_vec;
  logic [WIDTH-1:0] capture_vec;

  assign dense       = int'(ones_fn(state_i)) > WEIGHT_ABOVE;
  assign launch_vec  = state_i ^ rotl_fn(state_i, ROT_LAUNCH);
  assign capture_vec = state_i ^ rotl_fn(state_i, ROT_CAPTURE);

  always_comb begin
    unique case (mode_i)
      MODE_WEIGHT: vec_o = dense ? '1 : state_i;
      MODE_PAIR:   vec_o = second_i ? capture_vec : launch_vec;
      default:     vec_o = state_i;
    endcase
  end

endmodule

// File: rtl/wtpg_ctrl.sv
module wtpg_ctrl
  import wtpg_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int WEIGHT_ABOVE = (3 * WIDTH) / 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  mode_e            mode_i,
  input  logic [WIDTH-1:0] vec_i,
  output logic             second_o,
  output logic             adv_o,
  output logic [WIDTH-1:0] pattern_o,
  output logic             valid_o,
  output logic             capture_o
);

  logic emit;
  logic is_pair;
  logic phase_q;
  logic wmode_q;

  assign emit     = en_i && !load_i;
  assign is_pair  = (mode_i == MODE_PAIR);
  assign adv_o    = emit && (!is_pair || phase_q);
  assign second_o = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= 1'b0;
    else if (load_i) phase_q <= 1'b0;
    else if (emit)   phase_q <= is_pair && !phase_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pattern_o <= '0;
      valid_o   <= 1'b0;
      capture_o <= 1'b0;
      wmode_q   <= 1'b0;
    end else if (emit) begin
      pattern_o <= vec_i;
      valid_o   <= 1'b1;
      capture_o <= is_pair && phase_q;
      wmode_q   <= (mode_i == MODE_WEIGHT);
    end else begin
      valid_o   <= 1'b0;
      capture_o <= 1'b0;
      wmode_q   <= 1'b0;
    end
  end

  // R8
  launch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && is_pair && !phase_q) |=> (valid_o && !capture_o && phase_q));

  // R8
  capture_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && is_pair && phase_q) |=> (valid_o && capture_o && !phase_q));

  // R7
  weight_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wmode_q |-> (($countones(pattern_o) <= WEIGHT_ABOVE) || (pattern_o == '1)));

  // R9
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> (!valid_o && !capture_o && $stable(pattern_o)));

endmodule

// File: rtl/wtpg.sv
module wtpg
  import wtpg_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] TAPS         = 8'h1D,
  parameter logic [WIDTH-1:0] RESET_SEED   = {{(WIDTH-1){1'b0}}, 1'b1},
  parameter int               WEIGHT_ABOVE = (3 * WIDTH) / 4,
  parameter int               ROT_LAUNCH   = 1,
  parameter int               ROT_CAPTURE  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] pattern,
  output logic             valid,
  output logic             capture
);

  mode_e            mode_sel;
  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] shaped;
  logic             second;
  logic             adv;

  assign mode_sel = mode_e'(mode);

  wtpg_lfsr #(
    .WIDTH(WIDTH), .TAPS(TAPS), .RESET_SEED(RESET_SEED)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed),
    .adv_i(adv), .state_o(state)
  );

  wtpg_shaper #(
    .WIDTH(WIDTH), .WEIGHT_ABOVE(WEIGHT_ABOVE),
    .ROT_LAUNCH(ROT_LAUNCH), .ROT_CAPTURE(ROT_CAPTURE)
  ) u_shaper (
    .state_i(state), .mode_i(mode_sel), .second_i(second), .vec_o(shaped)
  );

  wtpg_ctrl #(
    .WIDTH(WIDTH), .WEIGHT_ABOVE(WEIGHT_ABOVE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .load_i(load), .mode_i(mode_sel),
    .vec_i(shaped), .second_o(second), .adv_o(adv),
    .pattern_o(pattern), .valid_o(valid), .capture_o(capture)
  );

  // R5
  load_blocks_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !valid);

endmodule

// File: tb/wtpg_bench.sv
module wtpg_bench;

  localparam int W = 8;
  localparam logic [W-1:0] TAPS_B = 8'h1D;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] seed = '0;
  logic [1:0]   mode = 2'd0;
  logic [W-1:0] pattern;
  logic         valid;
  logic         capture;
  logic [3:0]   pattern4;
  logic         valid4;
  logic         capture4;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [W-1:0] m_state;
  logic         m_phase;
  logic [W-1:0] e_pat;
  logic         e_val;
  logic         e_cap;

  always #4 clk = ~clk;

  wtpg u_wtpg (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .mode(mode),
    .pattern(pattern), .valid(valid), .capture(capture)
  );

  wtpg #(.WIDTH(4), .TAPS(4'b0011), .RESET_SEED(4'b0001)) u_wtpg_w4 (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed[3:0]), .mode(mode),
    .pattern(pattern4), .valid(valid4), .capture(capture4)
  );

  function automatic logic [W-1:0] b_next(input logic [W-1:0] s);
    logic fb;
    fb = 1'b0;
    for (int i = 0; i < W; i++) if (TAPS_B[i]) fb = fb ^ s[i];
    return (s >> 1) | ({{(W-1){1'b0}}, fb} << (W-1));
  endfunction

  function automatic logic [W-1:0] b_rot(input logic [W-1:0] s, input int k);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[(i + k) % W] = s[i];
    return r;
  endfunction

  function automatic int b_ones(input logic [W-1:0] s);
    int n;
    n = 0;
    for (int i = 0; i < W; i++) if (s[i]) n++;
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic e, input logic l, input logic [W-1:0] s,
                     input logic [1:0] m, input string tag);
    @(negedge clk);
    en = e; load = l; seed = s; mode = m;
    @(posedge clk);
    if (l) begin
      m_state = (s == '0) ? 8'h01 : s;
      m_phase = 1'b0;
      e_val = 1'b0; e_cap = 1'b0;
    end else if (e) begin
      e_val = 1'b1;
      if (m == 2'd2) begin
        if (!m_phase) begin
          e_pat = m_state ^ b_rot(m_state, 1); e_cap = 1'b0; m_phase = 1'b1;
        end else begin
          e_pat = m_state ^ b_rot(m_state, 2); e_cap = 1'b1; m_phase = 1'b0;
          m_state = b_next(m_state);
        end
      end else begin
        e_cap = 1'b0; m_phase = 1'b0;
        e_pat = (m == 2'd1 && b_ones(m_state) > 6) ? 8'hFF : m_state;
        m_state = b_next(m_state);
      end
    end else begin
      e_val = 1'b0; e_cap = 1'b0;
    end
    #1;
    chk(tag, 32'(valid), 32'(e_val));
    chk(tag, 32'(capture), 32'(e_cap));
    chk(tag, 32'(pattern), 32'(e_pat));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // seed, mode, enabled steps
  localparam int NT = 11;
  localparam logic [17:0] TABLE [NT] = '{
    {8'hA5, 2'd0, 8'd6},
    {8'hFE, 2'd1, 8'd1},
    {8'h3F, 2'd1, 8'd1},
    {8'h7F, 2'd1, 8'd1},
    {8'hFF, 2'd1, 8'd2},
    {8'h5A, 2'd1, 8'd24},
    {8'h96, 2'd2, 8'd10},
    {8'hC3, 2'd2, 8'd7},
    {8'h00, 2'd0, 8'd3},
    {8'h81, 2'd3, 8'd4},
    {8'h00, 2'd2, 8'd4}
  };

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    m_state = 8'h01; m_phase = 1'b0; e_pat = '0; e_val = 1'b0; e_cap = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R4 reset state
    chk("R4", 32'(valid), 0);
    chk("R4", 32'(capture), 0);
    chk("R4", 32'(pattern), 0);
    cyc(1'b1, 1'b0, 8'h00, 2'd0, "R4");

    // table walk
    for (int t = 0; t < NT; t++) begin
      logic [W-1:0] ts;
      logic [1:0]   tm;
      int           tn;
      string        tg;
      ts = TABLE[t][17:10]; tm = TABLE[t][9:8]; tn = int'(TABLE[t][7:0]);
      tg = (ts == 8'h00) ? "R3" : (tm == 2'd1) ? "R7" : (tm == 2'd2) ? "R8" : "R6";
      cyc(1'b0, 1'b1, ts, tm, "R5");
      for (int k = 0; k < tn; k++) cyc(1'b1, 1'b0, 8'h00, tm, tg);
    end

    // R1 on the 4-bit instance: 1001 -> 1100 -> 0110 -> 1011
    cyc(1'b0, 1'b1, 8'h09, 2'd0, "R5");
    begin
      logic [3:0] exp4 [4];
      exp4 = '{4'b1001, 4'b1100, 4'b0110, 4'b1011};
      for (int k = 0; k < 4; k++) begin
        cyc(1'b1, 1'b0, 8'h00, 2'd0, "R6");
        chk("R1", 32'(pattern4), 32'(exp4[k]));
        chk("R1", 32'(valid4), 1);
      end
    end

    // R5 load with enable high: no vector, then seed comes out
    cyc(1'b1, 1'b1, 8'h3C, 2'd0, "R5");
    chk("R5", 32'(valid), 0);
    cyc(1'b1, 1'b0, 8'h00, 2'd0, "R5");
    chk("R5", 32'(pattern), 32'h3C);

    // R9 idle cycles in the middle of a raw run
    cyc(1'b0, 1'b0, 8'h00, 2'd0, "R9");
    cyc(1'b0, 1'b0, 8'h00, 2'd1, "R9");
    cyc(1'b1, 1'b0, 8'h00, 2'd0, "R9");

    // R8 pair with a gap between launch and capture, then raw shows single advance
    cyc(1'b0, 1'b1, 8'h4D, 2'd2, "R8");
    cyc(1'b1, 1'b0, 8'h00, 2'd2, "R8");
    chk("R8", 32'(pattern), 32'(8'h4D ^ 8'h9A));
    cyc(1'b0, 1'b0, 8'h00, 2'd2, "R9");
    cyc(1'b1, 1'b0, 8'h00, 2'd2, "R8");
    chk("R8", 32'(capture), 1);
    chk("R8", 32'(pattern), 32'(8'h4D ^ 8'h35));
    cyc(1'b1, 1'b0, 8'h00, 2'd0, "R8");
    chk("R8", 32'(pattern), 32'(b_next(8'h4D)));
    // launch, then raw, then pair restarts at launch
    cyc(1'b1, 1'b0, 8'h00, 2'd2, "R8");
    cyc(1'b1, 1'b0, 8'h00, 2'd0, "R8");
    cyc(1'b1, 1'b0, 8'h00, 2'd2, "R8");
    chk("R8", 32'(capture), 0);

    // R2 full period from 8'h01
    cyc(1'b0, 1'b1, 8'h01, 2'd0, "R5");
    begin
      int  back_at;
      bit  saw_zero;
      back_at = 0; saw_zero = 1'b0;
      for (int k = 1; k <= 256; k++) begin
        cyc(1'b1, 1'b0, 8'h00, 2'd0, "R6");
        if (pattern == 8'h00) saw_zero = 1'b1;
        if (k > 1 && back_at == 0 && pattern == 8'h01) back_at = k;
      end
      chk("R2", 32'(back_at - 1), 255);
      chk("R2", 32'(saw_zero), 0);
    end

    finish_up();
  end

endmodule